// File: doc/BRIEF.md
# Vertical divider mode controller

This block generates the start of vertical retrace from a half-line-rate tick supplied by the horizontal oscillator. It counts half-lines since the last retrace. Depending on its current mode, an incoming vertical sync strobe either restarts that count or is ignored. Each retrace emits a one-cycle pulse that a downstream ramp generator consumes. Each retrace also latches the measured frame length in lines.

The block has three modes, which trade capture range against noise immunity. Search mode accepts sync anywhere in a wide window. Narrow mode accepts sync only within one half-line of the nominal field length. If sync is absent in narrow mode, the block retraces at the window edge as a flywheel. Fixed mode always retraces at the nominal length and uses sync only as a lock check. Runs of good pulses move the block towards fixed mode. Runs of missing pulses move it back towards search. A software bit can force search mode at once, for example after a tuner channel change.

Top module: `vdiv_ctrl`

## Requirements
- R1: The half-line counter advances only in cycles where `tick_i` is high, and `vsync_i` is evaluated only in those cycles. A strobe in a cycle without a tick has no effect. The mode changes only on a tick cycle or on `force_search_i`.
- R2: In search mode (`mode_o`=0), a sync at half-line position p, with 2*SRCH_LO_L <= p <= 2*SRCH_HI_L (defaults 488..722), restarts the divider. Syncs outside that range are ignored. With no accepted sync, retrace happens at p = 2*SRCH_HI_L. Positions count ticks since the previous retrace, starting at 1.
- R3: `retrace_o` is a one-cycle pulse in the cycle after the tick that caused it. In that same cycle, `line_cnt_o` takes floor(p/2) and then holds until the next retrace.
- R4: Search mode moves to narrow mode on the LOCK_N-th (default 16) consecutive retrace that meets two conditions: it comes from a sync with p in N-1..N+1, and floor(p/2) is within the standard line range. The standard range defaults to 311..314 at 50 Hz and 261..264 at 60 Hz. Any other search retrace clears the run.
- R5: In narrow mode (`mode_o`=1), only syncs at p in N-1..N+1 are accepted. With none, retrace happens at p = N+1 and counts as a miss.
- R6: After entry from search mode, MISS_NARROW_N (default 6) consecutive narrow misses return the block to search mode. An accepted sync clears the miss run.
- R7: Narrow mode moves to fixed mode on the NORM_N-th (default 15) consecutive accepted sync at exactly p = N. A sync at N±1 or a miss restarts this run.
- R8: In fixed mode (`mode_o`=2), retrace happens at exactly p = N every frame. A sync anywhere else neither restarts the divider nor counts as good.
- R9: MISS_FIXED_N (default 3) consecutive fixed-mode frames without a sync at p = N return the block to narrow mode. From there, MISS_RELOCK_N (default 3) consecutive misses return it to search mode. All run counters are cleared on every mode change.
- R10: `force_search_i` high for one clock puts the block in search mode on the next edge and clears all run counters.
- R11: Reset puts the block in search mode with `retrace_o`=0, `line_cnt_o`=0 and the position count at zero. `mode_o` never takes the value 3.
- R12: N is HL_50 (default 625 half-lines) when `sel_60_i`=0 and HL_60 (default 525) when `sel_60_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Half-line tick, one clock wide |
| vsync_i | input | 1 | Vertical sync strobe, evaluated on tick cycles |
| sel_60_i | input | 1 | 1 selects 60 Hz norm, 0 selects 50 Hz |
| force_search_i | input | 1 | Forces search mode |
| retrace_o | output | 1 | Vertical retrace start pulse |
| mode_o | output | 2 | 0 search, 1 narrow, 2 fixed |
| line_cnt_o | output | LN_W (9 by default) | Lines in the last frame |

## Verification
The bench builds the block with a scaled frame: HL_50=65 and HL_60=55 half-lines, a search window of lines 24..37, and standard ranges of 31..34 and 26..29 lines. The hysteresis counts stay at their default values. With these values, every mode transition fits into a few thousand ticks. These include the full 16-pulse lock, the 15-pulse norm run, both miss-return paths, the 60 Hz norm and forced search. Each frame's retrace position, line count and mode are predicted and compared against the pulses the block produces.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;
  typedef enum logic [1:0] {
    MODE_SEARCH = 2'd0,
    MODE_NARROW = 2'd1,
    MODE_FIXED  = 2'd2
  } vmode_e;
endpackage

// File: rtl/vdiv_hl_cnt.sv
module vdiv_hl_cnt #(
  parameter int HL_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            restart_i,
  output logic [HL_W-1:0] pos_o
);
  logic [HL_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= restart_i ? '0 : cnt_q + 1'b1;
  end

  // position of the half-line closing on this tick
  assign pos_o = cnt_q + 1'b1;

  assert_no_wrap_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !restart_i) |-> (cnt_q != '1));
endmodule

// File: rtl/vdiv_window.sv
module vdiv_window
  import vdiv_pkg::*;
#(
  parameter int HL_W       = 10,
  parameter int HL_50      = 625,
  parameter int HL_60      = 525,
  parameter int SRCH_LO_L  = 244,
  parameter int SRCH_HI_L  = 361,
  parameter int STD50_LO_L = 311,
  parameter int STD50_HI_L = 314,
  parameter int STD60_LO_L = 261,
  parameter int STD60_HI_L = 264
) (
  input  logic [HL_W-1:0] pos_i,
  input  vmode_e          mode_i,
  input  logic            sel_60_i,
  output logic            in_search_o,
  output logic            in_narrow_o,
  output logic            at_norm_o,
  output logic            at_end_o,
  output logic            is_std_o,
  output logic [HL_W-2:0] lines_o
);
  localparam logic [HL_W-1:0] N50     = HL_W'(HL_50);
  localparam logic [HL_W-1:0] N60     = HL_W'(HL_60);
  localparam logic [HL_W-1:0] SRCH_LO = HL_W'(2 * SRCH_LO_L);
  localparam logic [HL_W-1:0] SRCH_HI = HL_W'(2 * SRCH_HI_L);
  localparam logic [HL_W-2:0] S50_LO  = (HL_W-1)'(STD50_LO_L);
  localparam logic [HL_W-2:0] S50_HI  = (HL_W-1)'(STD50_HI_L);
  localparam logic [HL_W-2:0] S60_LO  = (HL_W-1)'(STD60_LO_L);
  localparam logic [HL_W-2:0] S60_HI  = (HL_W-1)'(STD60_HI_L);

  logic [HL_W-1:0] norm;
  logic [HL_W-2:0] std_lo, std_hi;

  assign lines_o = pos_i[HL_W-1:1];

  always_comb begin
    norm        = sel_60_i ? N60 : N50;
    std_lo      = sel_60_i ? S60_LO : S50_LO;
    std_hi      = sel_60_i ? S60_HI : S50_HI;
    in_search_o = (pos_i >= SRCH_LO) && (pos_i <= SRCH_HI);
    in_narrow_o = (pos_i >= norm - 1'b1) && (pos_i <= norm + 1'b1);
    at_norm_o   = (pos_i == norm);
    is_std_o    = (lines_o >= std_lo) && (lines_o <= std_hi);
    // >= keeps the counter bounded if the norm changes mid-frame
    unique case (mode_i)
      MODE_SEARCH: at_end_o = (pos_i >= SRCH_HI);
      MODE_NARROW: at_end_o = (pos_i >= norm + 1'b1);
      MODE_FIXED:  at_end_o = (pos_i >= norm);
      default:     at_end_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/vdiv_mode_fsm.sv
module vdiv_mode_fsm
  import vdiv_pkg::*;
#(
  parameter int HL_W          = 10,
  parameter int CNT_W         = 5,
  parameter int LOCK_N        = 16,
  parameter int NORM_N        = 15,
  parameter int MISS_NARROW_N = 6,
  parameter int MISS_FIXED_N  = 3,
  parameter int MISS_RELOCK_N = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            vsync_i,
  input  logic            force_search_i,
  input  logic            in_search_i,
  input  logic            in_narrow_i,
  input  logic            at_norm_i,
  input  logic            at_end_i,
  input  logic            is_std_i,
  input  logic [HL_W-2:0] lines_i,
  output vmode_e          mode_o,
  output logic            restart_o,
  output logic            retrace_o,
  output logic [HL_W-2:0] line_cnt_o
);
  localparam logic [CNT_W-1:0] LOCK_LAST   = CNT_W'(LOCK_N - 1);
  localparam logic [CNT_W-1:0] NORM_LAST   = CNT_W'(NORM_N - 1);
  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(MISS_NARROW_N - 1);
  localparam logic [CNT_W-1:0] FIXED_LAST  = CNT_W'(MISS_FIXED_N - 1);
  localparam logic [CNT_W-1:0] RELOCK_LAST = CNT_W'(MISS_RELOCK_N - 1);

  vmode_e           mode_q, mode_d;
  logic             relock_q, relock_d;
  logic [CNT_W-1:0] good_q, miss_q, miss_lim;
  logic             sync_ok, accept, retr;
  logic             good_inc, good_clr, miss_inc, miss_clr;

  assign sync_ok  = tick_i & vsync_i;
  assign miss_lim = relock_q ? RELOCK_LAST : NARROW_LAST;

  always_comb begin
    accept   = 1'b0;
    retr     = 1'b0;
    good_inc = 1'b0;
    good_clr = 1'b0;
    miss_inc = 1'b0;
    miss_clr = 1'b0;
    mode_d   = mode_q;
    relock_d = relock_q;
    unique case (mode_q)
      MODE_SEARCH: begin
        accept = sync_ok & in_search_i;
        retr   = tick_i & (accept | at_end_i);
        if (retr) begin
          if (accept && in_narrow_i && is_std_i) good_inc = 1'b1;
          else                                   good_clr = 1'b1;
        end
        if (good_inc && good_q == LOCK_LAST) mode_d = MODE_NARROW;
      end
      MODE_NARROW: begin
        accept = sync_ok & in_narrow_i;
        retr   = tick_i & (accept | at_end_i);
        if (accept) begin
          miss_clr = 1'b1;
          if (at_norm_i) good_inc = 1'b1;
          else           good_clr = 1'b1;
          if (at_norm_i && good_q == NORM_LAST) begin
            mode_d   = MODE_FIXED;
            relock_d = 1'b0;
          end
        end else if (retr) begin
          miss_inc = 1'b1;
          good_clr = 1'b1;
          if (miss_q == miss_lim) begin
            mode_d   = MODE_SEARCH;
            relock_d = 1'b0;
          end
        end
      end
      MODE_FIXED: begin
        retr = tick_i & at_end_i;
        if (retr) begin
          if (sync_ok && at_norm_i) miss_clr = 1'b1;
          else                      miss_inc = 1'b1;
        end
        if (miss_inc && miss_q == FIXED_LAST) begin
          mode_d   = MODE_NARROW;
          relock_d = 1'b1;
        end
      end
      default: mode_d = MODE_SEARCH;
    endcase
    if (force_search_i) begin
      mode_d   = MODE_SEARCH;
      relock_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_SEARCH;
      relock_q   <= 1'b0;
      good_q     <= '0;
      miss_q     <= '0;
      retrace_o  <= 1'b0;
      line_cnt_o <= '0;
    end else begin
      mode_q    <= mode_d;
      relock_q  <= relock_d;
      retrace_o <= retr;
      if (retr) line_cnt_o <= lines_i;
      if (mode_d != mode_q || force_search_i) begin
        good_q <= '0;
        miss_q <= '0;
      end else begin
        if (good_clr)      good_q <= '0;
        else if (good_inc) good_q <= good_q + 1'b1;
        if (miss_clr)      miss_q <= '0;
        else if (miss_inc) miss_q <= miss_q + 1'b1;
      end
    end
  end

  assign mode_o    = mode_q;
  assign restart_o = retr;

  assert_retrace_on_tick_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    retrace_o |-> $past(tick_i));
  assert_mode_quiet_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !force_search_i) |=> $stable(mode_q));
  assert_line_hold_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retrace_o |-> $stable(line_cnt_o));
  assert_search_no_skip_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SEARCH) |=> (mode_q != MODE_FIXED));
  assert_fixed_to_narrow_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_FIXED && !force_search_i) |=> (mode_q != MODE_SEARCH));
  assert_force_search_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_search_i |=> (mode_q == MODE_SEARCH));
  assert_mode_legal_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'd3);
endmodule

// File: rtl/vdiv_ctrl.sv
module vdiv_ctrl
  import vdiv_pkg::*;
#(
  parameter int HL_50         = 625,
  parameter int HL_60         = 525,
  parameter int SRCH_LO_L     = 244,
  parameter int SRCH_HI_L     = 361,
  parameter int STD50_LO_L    = 311,
  parameter int STD50_HI_L    = 314,
  parameter int STD60_LO_L    = 261,
  parameter int STD60_HI_L    = 264,
  parameter int LOCK_N        = 16,
  parameter int NORM_N        = 15,
  parameter int MISS_NARROW_N = 6,
  parameter int MISS_FIXED_N  = 3,
  parameter int MISS_RELOCK_N = 3,
  localparam int SRCH_END = 2 * SRCH_HI_L,
  localparam int MAX_A    = (SRCH_END > HL_50 + 1) ? SRCH_END : HL_50 + 1,
  localparam int MAX_POS  = (MAX_A > HL_60 + 1) ? MAX_A : HL_60 + 1,
  localparam int HL_W     = $clog2(MAX_POS + 1),
  localparam int LN_W     = HL_W - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            vsync_i,
  input  logic            sel_60_i,
  input  logic            force_search_i,
  output logic            retrace_o,
  output logic [1:0]      mode_o,
  output logic [LN_W-1:0] line_cnt_o
);
  localparam int MAX_C1  = (LOCK_N > NORM_N) ? LOCK_N : NORM_N;
  localparam int MAX_C2  = (MAX_C1 > MISS_NARROW_N) ? MAX_C1 : MISS_NARROW_N;
  localparam int MAX_C3  = (MAX_C2 > MISS_FIXED_N) ? MAX_C2 : MISS_FIXED_N;
  localparam int MAX_CNT = (MAX_C3 > MISS_RELOCK_N) ? MAX_C3 : MISS_RELOCK_N;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [HL_W-1:0] pos;
  logic [LN_W-1:0] lines;
  logic            restart;
  logic            in_search, in_narrow, at_norm, at_end, is_std;
  vmode_e          mode;

  vdiv_hl_cnt #(.HL_W(HL_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .restart_i (restart),
    .pos_o     (pos)
  );

  vdiv_window #(
    .HL_W(HL_W), .HL_50(HL_50), .HL_60(HL_60),
    .SRCH_LO_L(SRCH_LO_L), .SRCH_HI_L(SRCH_HI_L),
    .STD50_LO_L(STD50_LO_L), .STD50_HI_L(STD50_HI_L),
    .STD60_LO_L(STD60_LO_L), .STD60_HI_L(STD60_HI_L)
  ) u_win (
    .pos_i       (pos),
    .mode_i      (mode),
    .sel_60_i    (sel_60_i),
    .in_search_o (in_search),
    .in_narrow_o (in_narrow),
    .at_norm_o   (at_norm),
    .at_end_o    (at_end),
    .is_std_o    (is_std),
    .lines_o     (lines)
  );

  vdiv_mode_fsm #(
    .HL_W(HL_W), .CNT_W(CNT_W), .LOCK_N(LOCK_N), .NORM_N(NORM_N),
    .MISS_NARROW_N(MISS_NARROW_N), .MISS_FIXED_N(MISS_FIXED_N),
    .MISS_RELOCK_N(MISS_RELOCK_N)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_i         (tick_i),
    .vsync_i        (vsync_i),
    .force_search_i (force_search_i),
    .in_search_i    (in_search),
    .in_narrow_i    (in_narrow),
    .at_norm_i      (at_norm),
    .at_end_i       (at_end),
    .is_std_i       (is_std),
    .lines_i        (lines),
    .mode_o         (mode),
    .restart_o      (restart),
    .retrace_o      (retrace_o),
    .line_cnt_o     (line_cnt_o)
  );

  assign mode_o = mode;
endmodule

// File: tb/vdiv_ctrl_tb_top.sv
module vdiv_ctrl_tb_top;
  localparam int HL_50 = 65;
  localparam int HL_60 = 55;
  localparam int SLO   = 24;
  localparam int SHI   = 37;
  localparam int HL_W  = $clog2(2 * SHI + 1);
  localparam int LN_W  = HL_W - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, vsync_i = 1'b0, sel_60_i = 1'b0, force_search_i = 1'b0;
  logic            retrace_o;
  logic [1:0]      mode_o;
  logic [LN_W-1:0] line_cnt_o;

  always #10 clk = ~clk;

  vdiv_ctrl #(
    .HL_50(HL_50), .HL_60(HL_60), .SRCH_LO_L(SLO), .SRCH_HI_L(SHI),
    .STD50_LO_L(31), .STD50_HI_L(34), .STD60_LO_L(26), .STD60_HI_L(29)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .vsync_i(vsync_i),
    .sel_60_i(sel_60_i), .force_search_i(force_search_i),
    .retrace_o(retrace_o), .mode_o(mode_o), .line_cnt_o(line_cnt_o)
  );

  typedef struct {
    int p;
    int m;
  } exp_t;

  exp_t  q[$];
  string q_tag[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    tick_seen = 0;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per retrace pulse
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(negedge clk);
      if (!rst_ni) tick_seen = 0;
      else begin
        if (tick_i) tick_seen++;
        if (retrace_o) begin
          if (q.size() == 0) chk(1'b0, "R2", "unexpected retrace at", tick_seen, 0);
          else begin
            e = q.pop_front();
            t = q_tag.pop_front();
            chk(tick_seen == e.p, t, "retrace position", tick_seen, e.p);
            chk(int'(line_cnt_o) == e.p / 2, "R3", "line count", int'(line_cnt_o), e.p / 2);
            chk(int'(mode_o) == e.m, t, "mode after retrace", int'(mode_o), e.m);
          end
          tick_seen = 0;
        end
      end
    end
  end

  task automatic step(input bit t, input bit v);
    @(posedge clk);
    #2;
    tick_i  = t;
    vsync_i = v;
  endtask

  // sa/sb: syncs on tick k; off: sync in the idle cycle after tick k
  task automatic run_frame(input int sa, input int sb, input int off,
                           input int exp_p, input int exp_m, input string tag);
    exp_t e;
    e.p = exp_p;
    e.m = exp_m;
    q.push_back(e);
    q_tag.push_back(tag);
    for (int k = 1; k <= exp_p; k++) begin
      step(1'b1, (k == sa) || (k == sb));
      step(1'b0, k == off);
    end
  endtask

  task automatic do_force(input string tag);
    @(posedge clk);
    #2;
    force_search_i = 1'b1;
    @(posedge clk);
    #2;
    force_search_i = 1'b0;
    @(negedge clk);
    chk(mode_o == 2'd0, tag, "mode after force", int'(mode_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(mode_o == 2'd0, "R11", "reset mode", int'(mode_o), 0);
    chk(retrace_o == 1'b0, "R11", "reset retrace", int'(retrace_o), 0);
    chk(line_cnt_o == '0, "R11", "reset line count", int'(line_cnt_o), 0);
    rst_ni = 1'b1;

    // search window and flywheel, off-tick strobe ignored
    run_frame(50, 0, 0, 50, 0, "R2");
    run_frame(40, 0, 60, 74, 0, "R1");

    // lock run broken, then 16 in a row
    for (int i = 0; i < 10; i++) run_frame(65, 0, 0, 65, 0, "R4");
    run_frame(60, 0, 0, 60, 0, "R4");
    for (int i = 0; i < 15; i++) run_frame(65, 0, 0, 65, 0, "R4");
    run_frame(65, 0, 0, 65, 1, "R4");

    // narrow window edges and flywheel
    run_frame(64, 0, 0, 64, 1, "R5");
    run_frame(66, 0, 0, 66, 1, "R5");
    run_frame(60, 0, 0, 66, 1, "R5");
    for (int i = 0; i < 4; i++) run_frame(0, 0, 0, 66, 1, "R6");
    run_frame(65, 0, 0, 65, 1, "R6");
    for (int i = 0; i < 5; i++) run_frame(0, 0, 0, 66, 1, "R6");
    run_frame(65, 0, 0, 65, 1, "R6");
    for (int i = 0; i < 5; i++) run_frame(0, 0, 0, 66, 1, "R6");
    run_frame(0, 0, 0, 66, 0, "R6");

    // relock, then norm run broken by N+1, then 15 at N
    for (int i = 0; i < 15; i++) run_frame(65, 0, 0, 65, 0, "R4");
    run_frame(65, 0, 0, 65, 1, "R4");
    for (int i = 0; i < 13; i++) run_frame(65, 0, 0, 65, 1, "R7");
    run_frame(66, 0, 0, 66, 1, "R7");
    for (int i = 0; i < 14; i++) run_frame(65, 0, 0, 65, 1, "R7");
    run_frame(65, 0, 0, 65, 2, "R7");

    // fixed ratio
    run_frame(65, 0, 0, 65, 2, "R8");
    run_frame(64, 0, 0, 65, 2, "R8");
    run_frame(65, 0, 0, 65, 2, "R8");
    run_frame(0, 0, 0, 65, 2, "R9");
    run_frame(0, 0, 0, 65, 2, "R9");
    run_frame(65, 0, 0, 65, 2, "R9");
    run_frame(60, 0, 0, 65, 2, "R9");
    run_frame(0, 0, 0, 65, 2, "R9");
    run_frame(0, 0, 0, 65, 1, "R9");

    // narrow after fixed: shorter miss limit, fresh count
    run_frame(0, 0, 0, 66, 1, "R9");
    run_frame(0, 0, 0, 66, 1, "R9");
    run_frame(65, 0, 0, 65, 1, "R9");
    run_frame(0, 0, 0, 66, 1, "R9");
    run_frame(0, 0, 0, 66, 1, "R9");
    run_frame(0, 0, 0, 66, 0, "R9");

    // 60 Hz norm
    sel_60_i = 1'b1;
    for (int i = 0; i < 15; i++) run_frame(55, 0, 0, 55, 0, "R12");
    run_frame(55, 0, 0, 55, 1, "R12");
    run_frame(0, 0, 0, 56, 1, "R12");

    // forced search clears the lock run
    do_force("R10");
    for (int i = 0; i < 10; i++) run_frame(55, 0, 0, 55, 0, "R10");
    do_force("R10");
    for (int i = 0; i < 15; i++) run_frame(55, 0, 0, 55, 0, "R10");
    run_frame(55, 0, 0, 55, 1, "R10");

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R2", "pending retraces", q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule